// File: doc/BRIEF.md
# Register-Word Controlled Two-Wire Byte Access Master

This block is a two-wire serial (I2C) master that software drives through two 16-bit words: a command/status word and a byte-exchange word. A write to the command word starts exactly one single-byte random access to a register inside a pluggable optical transceiver. The access can be a read or a write. The command word also carries a page selector that picks one of two adjacent 7-bit device addresses, and an abort request. The byte to send sits in the upper half of the exchange word. The most recent byte fetched from the device appears in the lower half.

The bus side is open-drain. The block only ever pulls SCL or SDA low, and it reads back the wired SDA level. The SCL timing comes from a quarter-period divider. SDA moves only while SCL is low, except when the block forms a START or STOP condition. A device that fails to acknowledge its address or a byte sets a sticky error flag, and the access ends with a STOP.

Top module: `optoi2c_master`

## Requirements
- R1: After reset both words read 0x0000, and neither SCL nor SDA is pulled low.
- R2: A command-word write with bit 12 clear, made while idle, starts one access. Bit 14 (busy) reads 1 from the next cycle until the access ends. Bits 13 and 11..0 read back as written.
- R3: When command bit 11 is 1, the access is a write: START, address byte with R/W=0, command bits 7..0 as register number, byte-exchange bits 15..8 as data, STOP. Each byte is acknowledged.
- R4: When command bit 11 is 0, the access is a read: START, address+W, register number, repeated START, address+R, one byte received and answered with NACK, STOP. The byte lands in exchange bits 7..0.
- R5: Command bit 8 chooses the device: 0 gives address 7'h50 (bytes 0xA0/0xA1), 1 gives 7'h51 (bytes 0xA2/0xA3).
- R6: A missing acknowledge sets command bit 15 (error), issues STOP and ends busy. Bit 15 clears when the next access is launched.
- R7: Command-word writes made while busy neither start an access nor change bits 13 and 11..0.
- R8: Writing 1 to command bit 12 ends any access at once: busy and error clear, both lines are released on the next cycle, and bit 12 always reads 0.
- R9: Exchange bits 15..8 read back as written. Writes to exchange bits 7..0 have no effect.
- R10: SCL stays released for exactly 2*QUARTER clock cycles per pulse. SDA from the master changes while SCL is released only to form START or STOP.
- R11: While not busy, neither line is pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command/status word, 1 = byte-exchange word |
| reg_wdata | input | 16 | Write data |
| ctrl_rdata | output | 16 | Command/status word read value |
| data_rdata | output | 16 | Byte-exchange word read value |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Wired SDA level |

## Verification
The bench attaches a clocked two-wire device model that holds a 512-byte store over two pages. Accesses are run as writes and as reads on both pages and at several register numbers. The same register number on each page tells apart a page-bit fault from a register-number fault. Reading back a byte written earlier tells apart a data-path fault from an address-sequence fault. The model logs START/STOP counts, address bytes and the master's final acknowledge bit. These logs separate the repeated-START read from the plain write, and they show the NACK-then-STOP path when the device is made absent. A second command during busy checks that it is ignored. An abort in mid-address checks that the access is cut off and that the next access still works.

// File: rtl/optoi2c_pkg.sv
// Shared types and field positions for the two-wire byte access master.
package optoi2c_pkg;
    // Bit-level operations the line generator performs
    typedef enum logic [1:0] {
        BCMD_START = 2'd0,
        BCMD_STOP  = 2'd1,
        BCMD_BIT   = 2'd2
    } bcmd_t;

    // Transaction sequencer phases
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_START, SQ_TX, SQ_RSTART, SQ_RX, SQ_STOP
    } sq_state_t;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam logic [6:0]  DEV_BASE = 7'h50;

    // Command/status word field positions
    localparam int unsigned F_PAGE  = 8;
    localparam int unsigned F_WR    = 11;
    localparam int unsigned F_ABORT = 12;
    localparam int unsigned F_BUSY  = 14;
    localparam int unsigned F_ERR   = 15;
endpackage

// File: rtl/optoi2c_bitgen.sv
// Line generator: performs one START, STOP or data-bit slot on SCL/SDA.
// Each slot spans four quarters of QUARTER clocks. SCL is released in
// quarters 1 and 2. SDA is sampled at the end of quarter 2.
// Assumes: no clock stretching, so SCL is never read back.
module optoi2c_bitgen
    import optoi2c_pkg::*;
#(
    parameter int unsigned QUARTER = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  go,
    input  bcmd_t cmd,
    input  logic  txbit,
    input  logic  sda_in,
    output logic  busy,
    output logic  done,
    output logic  rxbit,
    output logic  scl_lvl,
    output logic  sda_lvl,
    output logic  cond_cmd
);
    localparam int unsigned CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

    logic [CW-1:0] cnt;
    logic [1:0]    qtr;
    bcmd_t         cmd_q;
    logic          bit_q;
    logic          qend;
    logic          scl_n, sda_n;

    assign qend     = (cnt == CW'(QUARTER - 1));
    assign cond_cmd = (cmd_q != BCMD_BIT);

    // Line levels wanted for the current quarter of the current slot
    always_comb begin
        case (cmd_q)
            BCMD_START: begin
                scl_n = (qtr == 2'd1) || (qtr == 2'd2);
                sda_n = !qtr[1];
            end
            BCMD_STOP: begin
                scl_n = (qtr != 2'd0);
                sda_n = qtr[1];
            end
            BCMD_BIT: begin
                scl_n = (qtr == 2'd1) || (qtr == 2'd2);
                sda_n = bit_q;
            end
            default: begin
                scl_n = 1'b1;
                sda_n = 1'b1;
            end
        endcase
    end

    // Slot timing, registered line levels and SDA sampling
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
            qtr     <= 2'd0;
            cmd_q   <= BCMD_STOP;
            bit_q   <= 1'b1;
            rxbit   <= 1'b0;
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy  <= 1'b1;
                    cnt   <= '0;
                    qtr   <= 2'd0;
                    cmd_q <= cmd;
                    bit_q <= txbit;
                end
            end else begin
                scl_lvl <= scl_n;
                sda_lvl <= sda_n;
                if (qtr == 2'd2 && qend)
                    rxbit <= sda_in;
                if (qend) begin
                    cnt <= '0;
                    qtr <= qtr + 2'd1;
                    if (qtr == 2'd3) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/optoi2c_seq.sv
// Transaction sequencer: runs the byte order of one random read or write.
// It issues bit slots to the line generator and checks each acknowledge.
// Assumes: fields are latched at launch and held for the whole access.
module optoi2c_seq
    import optoi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              launch,
    input  logic              l_page,
    input  logic              l_wr,
    input  logic [BYTE_W-1:0] l_reg,
    input  logic [BYTE_W-1:0] l_data,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_rx,
    output logic              go,
    output bcmd_t             cmd,
    output logic              txbit,
    output logic              busy,
    output logic              err,
    output logic              rd_done,
    output logic [BYTE_W-1:0] rd_byte
);
    sq_state_t         state;
    logic [3:0]        bitn;
    logic [1:0]        bsel;
    logic              page_q, wr_q;
    logic [BYTE_W-1:0] reg_q, dat_q, txbyte;

    assign busy    = (state != SQ_IDLE);
    assign go      = busy && !eng_busy && !eng_done;

    // Byte currently being shifted out
    always_comb begin
        case (bsel)
            2'd0:    txbyte = {DEV_BASE[6:1], page_q, 1'b0};
            2'd1:    txbyte = reg_q;
            2'd2:    txbyte = dat_q;
            default: txbyte = {DEV_BASE[6:1], page_q, 1'b1};
        endcase
    end

    // Bit-slot request for the present phase
    always_comb begin
        cmd   = BCMD_BIT;
        txbit = 1'b1;
        case (state)
            SQ_START, SQ_RSTART: cmd = BCMD_START;
            SQ_STOP:             cmd = BCMD_STOP;
            SQ_TX:               txbit = (bitn == 4'd8) ? 1'b1 : txbyte[3'(4'd7 - bitn)];
            default:             txbit = 1'b1;
        endcase
    end

    // Phase advance, acknowledge check and receive shifting
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state   <= SQ_IDLE;
            err     <= 1'b0;
            bitn    <= 4'd0;
            bsel    <= 2'd0;
            rd_done <= 1'b0;
            page_q  <= 1'b0;
            wr_q    <= 1'b0;
            reg_q   <= '0;
            dat_q   <= '0;
            rd_byte <= '0;
        end else begin
            rd_done <= 1'b0;
            if (state == SQ_IDLE) begin
                if (launch) begin
                    state  <= SQ_START;
                    err    <= 1'b0;
                    bsel   <= 2'd0;
                    bitn   <= 4'd0;
                    page_q <= l_page;
                    wr_q   <= l_wr;
                    reg_q  <= l_reg;
                    dat_q  <= l_data;
                end
            end else if (eng_done) begin
                case (state)
                    SQ_START: begin
                        state <= SQ_TX;
                        bitn  <= 4'd0;
                    end
                    SQ_RSTART: begin
                        state <= SQ_TX;
                        bitn  <= 4'd0;
                        bsel  <= 2'd3;
                    end
                    SQ_TX: begin
                        if (bitn != 4'd8) begin
                            bitn <= bitn + 4'd1;
                        end else if (eng_rx) begin
                            err   <= 1'b1;
                            state <= SQ_STOP;
                        end else begin
                            bitn <= 4'd0;
                            case (bsel)
                                2'd0: bsel <= 2'd1;
                                2'd1: if (wr_q) bsel <= 2'd2;
                                      else      state <= SQ_RSTART;
                                2'd2: state <= SQ_STOP;
                                default: state <= SQ_RX;
                            endcase
                        end
                    end
                    SQ_RX: begin
                        if (bitn != 4'd8) begin
                            rd_byte <= {rd_byte[6:0], eng_rx};
                            bitn    <= bitn + 4'd1;
                        end else begin
                            rd_done <= 1'b1;
                            state   <= SQ_STOP;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/optoi2c_master.sv
// Top: command/status and byte-exchange words around the sequencer and
// line generator. The outputs are open-drain pull requests (1 = pull low).
// Assumes: a single register port; SDA arrives already synchronous.
module optoi2c_master
    import optoi2c_pkg::*;
#(
    parameter int unsigned QUARTER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] ctrl_rdata,
    output logic [WORD_W-1:0] data_rdata,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              sda_in
);
    logic              ctl_wr, abort, launch;
    logic [13:0]       ctl_q;
    logic [BYTE_W-1:0] tx_q, rx_q;
    logic              sq_busy, sq_err, rd_done;
    logic [BYTE_W-1:0] rd_byte;
    logic              go, txbit, eng_busy, eng_done, eng_rx;
    logic              scl_lvl, sda_lvl, eng_cond;
    bcmd_t             cmd;

    assign ctl_wr = reg_wr && !reg_sel;
    assign abort  = ctl_wr && reg_wdata[F_ABORT];
    assign launch = ctl_wr && !reg_wdata[F_ABORT] && !sq_busy;

    assign ctrl_rdata = {sq_err, sq_busy, ctl_q[13], 1'b0, ctl_q[11:0]};
    assign data_rdata = {tx_q, rx_q};
    assign scl_pull   = !scl_lvl;
    assign sda_pull   = !sda_lvl;

    // Register words: command fields on launch, send byte, received byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            if (launch)
                ctl_q <= {reg_wdata[13], 1'b0, reg_wdata[11:0]};
            if (reg_wr && reg_sel)
                tx_q <= reg_wdata[15:8];
            if (rd_done)
                rx_q <= rd_byte;
        end
    end

    optoi2c_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .launch   (launch),
        .l_page   (reg_wdata[F_PAGE]),
        .l_wr     (reg_wdata[F_WR]),
        .l_reg    (reg_wdata[7:0]),
        .l_data   (tx_q),
        .eng_busy (eng_busy),
        .eng_done (eng_done),
        .eng_rx   (eng_rx),
        .go       (go),
        .cmd      (cmd),
        .txbit    (txbit),
        .busy     (sq_busy),
        .err      (sq_err),
        .rd_done  (rd_done),
        .rd_byte  (rd_byte)
    );

    optoi2c_bitgen #(.QUARTER(QUARTER)) u_bitgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (abort),
        .go       (go),
        .cmd      (cmd),
        .txbit    (txbit),
        .sda_in   (sda_in),
        .busy     (eng_busy),
        .done     (eng_done),
        .rxbit    (eng_rx),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .cond_cmd (eng_cond)
    );
endmodule

// File: rtl/optoi2c_master_chk.sv
// Property checker for optoi2c_master, attached by bind.
module optoi2c_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [15:0] reg_wdata,
    input logic [15:0] ctrl_rdata,
    input logic [15:0] data_rdata,
    input logic        scl_pull,
    input logic        sda_pull,
    input logic        cond_cmd
);
    logic busy, err, abort_wr;
    assign busy     = ctrl_rdata[14];
    assign err      = ctrl_rdata[15];
    assign abort_wr = reg_wr && !reg_sel && reg_wdata[12];

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && $past(reg_wr && !reg_sel)) |-> $stable({ctrl_rdata[13], ctrl_rdata[11:0]}));

    // R9
    data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && !busy) |=> $stable(data_rdata[7:0]));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> (!busy && !err && !scl_pull && !sda_pull && !ctrl_rdata[12]));

    // R6
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));

    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !reg_wdata[12] && !busy) |=> (busy && !err));

    // R10
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull)) && !$past(abort_wr))
            |-> $past(cond_cmd));
endmodule

bind optoi2c_master optoi2c_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .ctrl_rdata (ctrl_rdata),
    .data_rdata (data_rdata),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .cond_cmd   (eng_cond)
);

// File: tb/optoi2c_master_bench.sv
`timescale 1ns/1ps
module optoi2c_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctrl_rdata, data_rdata;
    logic        scl_pull, sda_pull, sda_in;
    logic        scl_bus, sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Device model state
    logic       slv_drv = 1'b0;
    logic       dev_absent = 1'b0;
    logic [7:0] mem [512];
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic [2:0] st = 3'd0;
    logic [3:0] bc = 4'd0;
    logic [1:0] idx = 2'd0;
    logic [7:0] sh = 8'd0, ptr = 8'd0, txb = 8'd0;
    logic       pg = 1'b0, rdm = 1'b0, mnack = 1'b0;
    logic [7:0] last_wa = 8'd0, last_ra = 8'd0;
    int n_start = 0, n_stop = 0, hi_cnt = 0, last_hi = 0;

    localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_ACK = 3'd2, S_TX = 3'd3, S_MACK = 3'd4;

    assign scl_bus = !scl_pull;
    assign sda_bus = !(sda_pull || slv_drv);
    assign sda_in  = sda_bus;

    optoi2c_master u_optoi2c_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in)
    );

    function automatic logic [7:0] ival(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // Clocked two-wire device model with two 256-byte pages
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= ival(i);
            st <= S_IDLE; slv_drv <= 1'b0;
        end else begin
            if (scl_bus) hi_cnt <= hi_cnt + 1;
            else         hi_cnt <= 0;
            if (p_scl && scl_bus && p_sda && !sda_bus) begin
                st <= S_RX; bc <= 4'd0; idx <= 2'd0; slv_drv <= 1'b0; n_start <= n_start + 1;
            end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
                st <= S_IDLE; slv_drv <= 1'b0; n_stop <= n_stop + 1;
            end else if (!p_scl && scl_bus) begin
                if (st == S_RX) begin sh <= {sh[6:0], sda_bus}; bc <= bc + 4'd1; end
                else if (st == S_TX) bc <= bc + 4'd1;
                else if (st == S_MACK) mnack <= sda_bus;
            end else if (p_scl && !scl_bus) begin
                last_hi <= hi_cnt;
                case (st)
                    S_RX: if (bc == 4'd8) begin
                        idx <= idx + 2'd1;
                        if (idx == 2'd0) begin
                            if (sh[0]) last_ra <= sh; else last_wa <= sh;
                            if (!dev_absent && (sh[7:1] == 7'h50 || sh[7:1] == 7'h51)) begin
                                pg <= sh[1]; rdm <= sh[0];
                                txb <= mem[{sh[1], ptr}];
                                slv_drv <= 1'b1; st <= S_ACK;
                            end else st <= S_IDLE;
                        end else begin
                            if (idx == 2'd1) ptr <= sh;
                            else mem[{pg, ptr}] <= sh;
                            slv_drv <= 1'b1; st <= S_ACK;
                        end
                    end
                    S_ACK: begin
                        bc <= 4'd0;
                        if (rdm) begin st <= S_TX; slv_drv <= !txb[7]; end
                        else begin st <= S_RX; slv_drv <= 1'b0; end
                    end
                    S_TX: if (bc == 4'd8) begin slv_drv <= 1'b0; st <= S_MACK; end
                          else slv_drv <= !txb[3'(4'd7 - bc)];
                    S_MACK: st <= S_IDLE;
                    default: ;
                endcase
            end
            p_scl <= scl_bus;
            p_sda <= sda_bus;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (ctrl_rdata[14] && t < 5000) begin @(negedge clk); t++; end
        chk({req, " completes"}, 16'(ctrl_rdata[14]), 16'd0);
    endtask

    task automatic t_reset;
        chk("R1 control word", ctrl_rdata, 16'h0000);
        chk("R1 exchange word", data_rdata, 16'h0000);
        chk("R11 lines released", {14'd0, scl_pull, sda_pull}, 16'd0);
    endtask

    task automatic t_data_reg;
        wr_reg(1'b1, 16'hABCD);
        chk("R9 high byte kept, low ignored", data_rdata, 16'hAB00);
    endtask

    task automatic t_write(input logic page, input logic [7:0] rn, input logic [7:0] d, input string req);
        int s0, p0;
        wr_reg(1'b1, {d, 8'h00});
        s0 = n_start; p0 = n_stop;
        wr_reg(1'b0, {4'h0, 3'b100, page, rn});
        chk("R2 busy and fields", ctrl_rdata, {4'h4, 3'b100, page, rn});
        wait_idle(req);
        chk({req, " stored byte"}, 16'(mem[{page, rn}]), 16'(d));
        chk({req, " address byte"}, 16'(last_wa), 16'({7'b1010000, 1'b0} | {6'd0, page, 1'b0}));
        chk("R3 one START", 16'(n_start - s0), 16'd1);
        chk("R3 one STOP", 16'(n_stop - p0), 16'd1);
        chk("R6 no error", ctrl_rdata, {4'h0, 3'b100, page, rn});
        chk("R10 SCL high time", 16'(last_hi), 16'd8);
    endtask

    task automatic t_read(input logic page, input logic [7:0] rn, input logic [7:0] exp);
        int s0, p0;
        s0 = n_start; p0 = n_stop;
        wr_reg(1'b0, {7'h00, page, rn});
        wait_idle("R4");
        chk("R4 received byte", 16'(data_rdata[7:0]), 16'(exp));
        chk("R4 repeated START", 16'(n_start - s0), 16'd2);
        chk("R4 one STOP", 16'(n_stop - p0), 16'd1);
        chk("R5 read address byte", 16'(last_ra), 16'({7'b1010000, 1'b1} | {6'd0, page, 1'b0}));
        chk("R4 master NACK", 16'(mnack), 16'd1);
    endtask

    task automatic t_busy_ignore;
        int p0;
        logic [7:0] lo;
        lo = data_rdata[7:0];
        p0 = n_stop;
        wr_reg(1'b0, 16'h0820);
        repeat (10) @(negedge clk);
        wr_reg(1'b0, 16'h0155);
        chk("R7 fields unchanged while busy", ctrl_rdata, 16'h4820);
        wait_idle("R7");
        chk("R7 single access", 16'(n_stop - p0), 16'd1);
        chk("R7 first access done", 16'(mem[9'h020]), 16'h0077);
        chk("R7 fields after", ctrl_rdata, 16'h0820);
        wr_reg(1'b1, 16'h12FF);
        chk("R9 low byte ignores write", data_rdata, {8'h12, lo});
    endtask

    task automatic t_nack;
        int p0;
        logic [7:0] lo;
        lo = data_rdata[7:0];
        dev_absent = 1'b1;
        p0 = n_stop;
        wr_reg(1'b0, 16'h0005);
        wait_idle("R6");
        chk("R6 error set, busy clear", ctrl_rdata, 16'h8005);
        chk("R6 STOP after NACK", 16'(n_stop - p0), 16'd1);
        chk("R6 low byte untouched", 16'(data_rdata[7:0]), 16'(lo));
        dev_absent = 1'b0;
        wr_reg(1'b0, 16'h0806);
        chk("R6 error cleared at launch", ctrl_rdata, 16'h4806);
        wait_idle("R6");
        chk("R6 clean access", ctrl_rdata, 16'h0806);
    endtask

    task automatic t_abort;
        wr_reg(1'b1, 16'h3400);
        wr_reg(1'b0, 16'h0830);
        repeat (60) @(negedge clk);
        chk("R8 busy before abort", 16'(ctrl_rdata[14]), 16'd1);
        wr_reg(1'b0, 16'h1000);
        chk("R8 abort ends access", ctrl_rdata, 16'h0830);
        chk("R8 lines released", {14'd0, scl_pull, sda_pull}, 16'd0);
        repeat (40) @(negedge clk);
        chk("R8 nothing written", 16'(mem[9'h030]), 16'(ival(9'h030)));
        t_read(1'b1, 8'h12, 8'h77);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_reg();
        t_write(1'b0, 8'h12, 8'h5C, "R3");
        t_write(1'b1, 8'h12, 8'h77, "R5");
        chk("R5 other page kept", 16'(mem[9'h012]), 16'h005C);
        t_read(1'b1, 8'h12, 8'h77);
        t_read(1'b0, 8'h40, ival(9'h040));
        t_busy_ignore();
        t_nack();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule